// File: doc/BRIEF.md
# Convolution Weight Stream Address Sequencer

This block produces the sequence of weight coordinates that a convolution engine's weight decoder expects, one coordinate per accepted cycle. The weights of one brick are held as kernel row, kernel column, input channel and output channel. The sequencer walks them through a fixed nesting of loops: output blocks, input blocks, subkernel tiles, micro-blocks, kernel elements and micro-block lanes. Each position is emitted as (wy, wx, input channel, output channel). A pad flag marks positions that lie outside the real weight volume and must be fed as zero.

One of three walk orders is chosen with the configuration: depth-first, part-kernel-first or depthwise. Each order has its own loop nesting and its own rounding of the number of kernel elements per subkernel. The configuration is taken when a start pulse arrives while the block is idle. Coordinates then leave over a valid/ready handshake. After the final coordinate has been accepted, a one-cycle done pulse follows.

Top module: `wss_seq`

## Requirements
- R1: While reset is low, and in the cycle after it is released, `out_valid` and `done` are 0.
- R2: With `cfg_mode` = 0 (depth-first; code 3 behaves the same), the nesting from outermost to innermost is: output block, input block, subkernel row, subkernel column, output micro-block, kernel element, input micro-block, output lane, input lane. The input block spans 32 channels for 8-bit input (`cfg_wide` = 0) and 16 for 16-bit input (`cfg_wide` = 1), and it is never clipped to the input depth.
- R3: With `cfg_mode` = 1 (part-kernel-first), the input block spans 16 channels clipped to the remaining input depth. The input micro-block loop sits outside the output micro-block loop, and no input micro-block loop is left inside the element loop. The subkernel element count is rounded up to a multiple of 4 for 8-bit input and of 2 for 16-bit input.
- R4: With `cfg_mode` = 2 (depthwise), there is one input block of micro-block depth. The element count is rounded up to a multiple of 4, the input lane loop runs once, and `out_ic` is 0.
- R5: The kernel is cut into tiles of at most `SUB_H` rows by `SUB_W` columns, and the last tile in each direction is clipped to the rows or columns left. Element index e maps to kx = e mod tile width and ky = e div tile width, so `out_wx` = tile column base + kx and `out_wy` = tile row base + ky.
- R6: `out_zero` is 1 exactly when `out_ic` >= input depth, `out_oc` >= output depth, or ky >= tile height.
- R7: While `out_valid` is 1 and `out_ready` is 0, all outputs and the walk position hold.
- R8: `done` pulses for one cycle, in the cycle after the last coordinate is accepted, with `out_valid` already 0. `out_valid` never drops before that point.
- R9: A start pulse while a walk is in progress, and any change to the configuration inputs during a walk, have no effect on the emitted sequence.
- R10: Each output block covers `cfg_oblk` channels, clipped to the remaining output depth, and is stepped in output micro-blocks of `OUB` lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a walk when the block is idle |
| cfg_kh | input | K_W | Kernel height (>= 1) |
| cfg_kw | input | K_W | Kernel width (>= 1) |
| cfg_idepth | input | D_W | Input channel count (>= 1) |
| cfg_odepth | input | D_W | Output channel count of the brick (>= 1) |
| cfg_oblk | input | D_W | Output block depth (>= 1) |
| cfg_mode | input | 2 | 0 depth-first, 1 part-kernel-first, 2 depthwise, 3 as 0 |
| cfg_wide | input | 1 | 1 = 16-bit input data, 0 = 8-bit |
| out_valid | output | 1 | A coordinate is presented |
| out_ready | input | 1 | Consumer accepts the coordinate |
| out_wy | output | CW | Kernel row of the weight |
| out_wx | output | CW | Kernel column of the weight |
| out_ic | output | D_W+1 | Input channel of the weight |
| out_oc | output | D_W+1 | Output channel of the weight |
| out_zero | output | 1 | Position is padding, feed zero |
| done | output | 1 | One-cycle pulse after the final acceptance |

## Verification
The bench builds the block with 8 by 8 tiles, 8-lane micro-blocks on both sides, 4-bit kernel sizes and 10-bit depths. A 10 by 9 kernel therefore needs four tiles: one full tile, two edge tiles clipped on one side each, and one corner tile clipped on both. With 8-lane micro-blocks, depths of 5, 10, 12 and 20 leave partly filled micro-blocks and blocks, so padding in channels, in rows and in clipped output blocks is all exercised. A pseudo-random ready pattern drives stalls on both long and short walks.

// File: rtl/wss_pkg.sv
// Shared definitions for the weight stream sequencer.
package wss_pkg;
    // Walk order selector; code 3 is treated as depth-first.
    typedef enum logic [1:0] {
        WM_DEPTH = 2'd0,
        WM_PART  = 2'd1,
        WM_DWISE = 2'd2,
        WM_RSVD  = 2'd3
    } walk_mode_e;
endpackage

// File: rtl/wss_geom.sv
// wss_geom: combinational tile and block geometry for the current walk position.
// Computes clipped tile height and width, the rounded element count, the input
// block span and the clipped input/output block depths.
// Assumes sy < kh, sx < kw, ibz < idepth and obz < odepth (the walker keeps these).
module wss_geom
    import wss_pkg::*;
#(
    parameter int K_W   = 4,
    parameter int D_W   = 10,
    parameter int SUB_H = 8,
    parameter int SUB_W = 8,
    localparam int SK_W = $clog2(((SUB_H > SUB_W) ? SUB_H : SUB_W) + 1),
    localparam int EL_W = $clog2(SUB_H * SUB_W + 4)
) (
    input  walk_mode_e       mode,
    input  logic             wide,
    input  logic [K_W-1:0]   kh,
    input  logic [K_W-1:0]   kw,
    input  logic [D_W-1:0]   idepth,
    input  logic [D_W-1:0]   odepth,
    input  logic [D_W-1:0]   oblk,
    input  logic [K_W-1:0]   sy,
    input  logic [K_W-1:0]   sx,
    input  logic [D_W-1:0]   ibz,
    input  logic [D_W-1:0]   obz,
    output logic [SK_W-1:0]  sh,
    output logic [SK_W-1:0]  sw,
    output logic [EL_W-1:0]  nelem,
    output logic [D_W-1:0]   ibd,
    output logic [D_W-1:0]   cibd,
    output logic [D_W-1:0]   cobd
);
    logic [K_W-1:0]  rem_h;
    logic [K_W-1:0]  rem_w;
    logic [D_W-1:0]  rem_i;
    logic [D_W-1:0]  rem_o;
    logic [EL_W-1:0] area;

    // Tile clipping, element rounding per mode and block depth clipping.
    always_comb begin
        rem_h = kh - sy;
        rem_w = kw - sx;
        sh    = (int'(rem_h) > SUB_H) ? SK_W'(SUB_H) : SK_W'(rem_h);
        sw    = (int'(rem_w) > SUB_W) ? SK_W'(SUB_W) : SK_W'(rem_w);
        area  = EL_W'(sh) * EL_W'(sw);
        case (mode)
            WM_PART:  nelem = wide ? ((area + EL_W'(1)) & ~EL_W'(1))
                                   : ((area + EL_W'(3)) & ~EL_W'(3));
            WM_DWISE: nelem = (area + EL_W'(3)) & ~EL_W'(3);
            default:  nelem = area;
        endcase
        ibd   = ((mode == WM_PART) || wide) ? D_W'(16) : D_W'(32);
        rem_i = idepth - ibz;
        cibd  = (rem_i < ibd) ? rem_i : ibd;
        rem_o = odepth - obz;
        cobd  = (rem_o < oblk) ? rem_o : oblk;
    end
endmodule

// File: rtl/wss_walk.sv
// wss_walk: the nested loop counters of the weight walk.
// One step per 'fire'; an inner counter wraps and carries into the next one out.
// The loop order depends on the mode: the input micro-block step is placed
// outside the output micro-blocks (part-kernel-first) or inside the element
// loop (other modes) by choosing which of the two has a single iteration.
// Assumes geometry inputs are derived from the current counter values.
module wss_walk
    import wss_pkg::*;
#(
    parameter int K_W   = 4,
    parameter int D_W   = 10,
    parameter int OUB   = 8,
    parameter int IUB   = 8,
    parameter int SUB_H = 8,
    parameter int SUB_W = 8,
    localparam int SK_W = $clog2(((SUB_H > SUB_W) ? SUB_H : SUB_W) + 1),
    localparam int EL_W = $clog2(SUB_H * SUB_W + 4),
    localparam int OZ_W = $clog2(OUB),
    localparam int IZ_W = $clog2(IUB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             fire,
    input  walk_mode_e       mode,
    input  logic [K_W-1:0]   kh,
    input  logic [K_W-1:0]   kw,
    input  logic [D_W-1:0]   idepth,
    input  logic [D_W-1:0]   odepth,
    input  logic [D_W-1:0]   oblk,
    input  logic [SK_W-1:0]  sw,
    input  logic [EL_W-1:0]  nelem,
    input  logic [D_W-1:0]   ibd,
    input  logic [D_W-1:0]   cibd,
    input  logic [D_W-1:0]   cobd,
    output logic [D_W-1:0]   obz,
    output logic [D_W-1:0]   ibz,
    output logic [K_W-1:0]   sy,
    output logic [K_W-1:0]   sx,
    output logic [D_W-1:0]   iuo,
    output logic [D_W-1:0]   ou,
    output logic [SK_W-1:0]  kx,
    output logic [EL_W-1:0]  ky,
    output logic [D_W-1:0]   iui,
    output logic [OZ_W-1:0]  oz,
    output logic [IZ_W-1:0]  iz,
    output logic             last
);
    logic [EL_W-1:0] el;
    logic is_part, is_dw;
    logic l_iz, l_oz, l_iui, l_el, l_ou, l_iuo, l_sx, l_sy, l_ib, l_ob;
    int   inner_lim, outer_lim;

    // Per-level "final iteration" flags.
    always_comb begin
        is_part   = (mode == WM_PART);
        is_dw     = (mode == WM_DWISE);
        inner_lim = is_part ? 1 : (is_dw ? IUB : int'(ibd));
        outer_lim = is_part ? int'(cibd) : 1;
        l_iz  = is_dw || (int'(iz) == IUB - 1);
        l_oz  = (int'(oz) == OUB - 1);
        l_iui = (int'(iui) + IUB) >= inner_lim;
        l_el  = (int'(el) + 1) >= int'(nelem);
        l_ou  = (int'(ou) + OUB) >= int'(cobd);
        l_iuo = (int'(iuo) + IUB) >= outer_lim;
        l_sx  = (int'(sx) + SUB_W) >= int'(kw);
        l_sy  = (int'(sy) + SUB_H) >= int'(kh);
        l_ib  = is_dw || ((int'(ibz) + int'(ibd)) >= int'(idepth));
        l_ob  = (int'(obz) + int'(oblk)) >= int'(odepth);
        last  = l_iz && l_oz && l_iui && l_el && l_ou && l_iuo
                && l_sx && l_sy && l_ib && l_ob;
    end

    // Counter chain: step innermost, carry outward on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            obz <= '0; ibz <= '0; sy <= '0; sx <= '0; iuo <= '0; ou <= '0;
            el  <= '0; kx  <= '0; ky <= '0; iui <= '0; oz <= '0; iz <= '0;
        end else if (fire) begin
            if (!l_iz) iz <= iz + IZ_W'(1);
            else begin
                iz <= '0;
                if (!l_oz) oz <= oz + OZ_W'(1);
                else begin
                    oz <= '0;
                    if (!l_iui) iui <= iui + D_W'(IUB);
                    else begin
                        iui <= '0;
                        if (!l_el) begin
                            el <= el + EL_W'(1);
                            if ((int'(kx) + 1) >= int'(sw)) begin
                                kx <= '0;
                                ky <= ky + EL_W'(1);
                            end else begin
                                kx <= kx + SK_W'(1);
                            end
                        end else begin
                            el <= '0; kx <= '0; ky <= '0;
                            if (!l_ou) ou <= ou + D_W'(OUB);
                            else begin
                                ou <= '0;
                                if (!l_iuo) iuo <= iuo + D_W'(IUB);
                                else begin
                                    iuo <= '0;
                                    if (!l_sx) sx <= sx + K_W'(SUB_W);
                                    else begin
                                        sx <= '0;
                                        if (!l_sy) sy <= sy + K_W'(SUB_H);
                                        else begin
                                            sy <= '0;
                                            if (!l_ib) ibz <= ibz + ibd;
                                            else begin
                                                ibz <= '0;
                                                if (!l_ob) obz <= obz + oblk;
                                                else obz <= '0;
                                            end
                                        end
                                    end
                                end
                            end
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/wss_seq.sv
// wss_seq: convolution weight stream address sequencer (top).
// Latches the configuration on a start pulse while idle, then presents one
// weight coordinate per accepted cycle and pulses done after the last one.
// Assumes all configuration sizes are at least 1 and that OUB, IUB >= 2.
module wss_seq
    import wss_pkg::*;
#(
    parameter int K_W   = 4,
    parameter int D_W   = 10,
    parameter int OUB   = 8,
    parameter int IUB   = 8,
    parameter int SUB_H = 8,
    parameter int SUB_W = 8,
    localparam int SK_W = $clog2(((SUB_H > SUB_W) ? SUB_H : SUB_W) + 1),
    localparam int EL_W = $clog2(SUB_H * SUB_W + 4),
    localparam int OZ_W = $clog2(OUB),
    localparam int IZ_W = $clog2(IUB),
    localparam int CW   = ((K_W > EL_W) ? K_W : EL_W) + 1,
    localparam int OCW  = D_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [K_W-1:0]   cfg_kh,
    input  logic [K_W-1:0]   cfg_kw,
    input  logic [D_W-1:0]   cfg_idepth,
    input  logic [D_W-1:0]   cfg_odepth,
    input  logic [D_W-1:0]   cfg_oblk,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_wide,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [CW-1:0]    out_wy,
    output logic [CW-1:0]    out_wx,
    output logic [OCW-1:0]   out_ic,
    output logic [OCW-1:0]   out_oc,
    output logic             out_zero,
    output logic             done
);
    walk_mode_e      mode_q;
    logic            wide_q;
    logic [K_W-1:0]  kh_q, kw_q;
    logic [D_W-1:0]  idepth_q, odepth_q, oblk_q;
    logic            busy, done_q, start_go, fire, last;

    logic [SK_W-1:0] sh, sw;
    logic [EL_W-1:0] nelem;
    logic [D_W-1:0]  ibd, cibd, cobd;
    logic [D_W-1:0]  obz, ibz, iuo, ou, iui;
    logic [K_W-1:0]  sy, sx;
    logic [SK_W-1:0] kx;
    logic [EL_W-1:0] ky;
    logic [OZ_W-1:0] oz;
    logic [IZ_W-1:0] iz;

    assign start_go = start && !busy;
    assign fire     = busy && out_ready;

    // Configuration capture, only when a walk begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= WM_DEPTH; wide_q <= 1'b0;
            kh_q <= '0; kw_q <= '0;
            idepth_q <= '0; odepth_q <= '0; oblk_q <= '0;
        end else if (start_go) begin
            mode_q   <= walk_mode_e'(cfg_mode);
            wide_q   <= cfg_wide;
            kh_q     <= cfg_kh;
            kw_q     <= cfg_kw;
            idepth_q <= cfg_idepth;
            odepth_q <= cfg_odepth;
            oblk_q   <= cfg_oblk;
        end
    end

    // Busy flag and the end-of-walk pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= fire && last;
            if (start_go) busy <= 1'b1;
            else if (fire && last) busy <= 1'b0;
        end
    end

    wss_geom #(.K_W(K_W), .D_W(D_W), .SUB_H(SUB_H), .SUB_W(SUB_W)) u_geom (
        .mode(mode_q), .wide(wide_q), .kh(kh_q), .kw(kw_q),
        .idepth(idepth_q), .odepth(odepth_q), .oblk(oblk_q),
        .sy(sy), .sx(sx), .ibz(ibz), .obz(obz),
        .sh(sh), .sw(sw), .nelem(nelem), .ibd(ibd), .cibd(cibd), .cobd(cobd)
    );

    wss_walk #(.K_W(K_W), .D_W(D_W), .OUB(OUB), .IUB(IUB),
               .SUB_H(SUB_H), .SUB_W(SUB_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .restart(start_go), .fire(fire),
        .mode(mode_q), .kh(kh_q), .kw(kw_q),
        .idepth(idepth_q), .odepth(odepth_q), .oblk(oblk_q),
        .sw(sw), .nelem(nelem), .ibd(ibd), .cibd(cibd), .cobd(cobd),
        .obz(obz), .ibz(ibz), .sy(sy), .sx(sx), .iuo(iuo), .ou(ou),
        .kx(kx), .ky(ky), .iui(iui), .oz(oz), .iz(iz), .last(last)
    );

    // Coordinate assembly and padding decision.
    always_comb begin
        out_valid = busy;
        done      = done_q;
        out_wy    = CW'(sy) + CW'(ky);
        out_wx    = CW'(sx) + CW'(kx);
        out_ic    = OCW'(ibz) + OCW'(iuo) + OCW'(iui) + OCW'(iz);
        out_oc    = OCW'(obz) + OCW'(ou) + OCW'(oz);
        out_zero  = (int'(out_ic) >= int'(idepth_q))
                 || (int'(out_oc) >= int'(odepth_q))
                 || (int'(ky) >= int'(sh));
    end
endmodule

// File: rtl/wss_seq_chk.sv
// wss_seq_chk: protocol and range properties of the weight stream sequencer.
// Keeps its own copy of the sizes seen on an accepted start pulse.
module wss_seq_chk #(
    parameter int K_W = 4,
    parameter int D_W = 10,
    parameter int CW  = 8,
    parameter int OCW = 11
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [K_W-1:0]  cfg_kh,
    input logic [K_W-1:0]  cfg_kw,
    input logic [D_W-1:0]  cfg_idepth,
    input logic [D_W-1:0]  cfg_odepth,
    input logic [1:0]      cfg_mode,
    input logic            out_valid,
    input logic            out_ready,
    input logic [CW-1:0]   out_wy,
    input logic [CW-1:0]   out_wx,
    input logic [OCW-1:0]  out_ic,
    input logic [OCW-1:0]  out_oc,
    input logic            out_zero,
    input logic            done
);
    logic [K_W-1:0] kh_c, kw_c;
    logic [D_W-1:0] id_c, od_c;
    logic [1:0]     md_c;

    // Observed configuration of the walk in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kh_c <= '0; kw_c <= '0; id_c <= '0; od_c <= '0; md_c <= '0;
        end else if (start && !out_valid) begin
            kh_c <= cfg_kh; kw_c <= cfg_kw;
            id_c <= cfg_idepth; od_c <= cfg_odepth; md_c <= cfg_mode;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !done); // R1

    AST_DWISE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (md_c == 2'd2) |-> out_ic == '0); // R4

    AST_REAL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_zero |-> (int'(out_ic) < int'(id_c)) && (int'(out_oc) < int'(od_c))
                                  && (int'(out_wy) < int'(kh_c)) && (int'(out_wx) < int'(kw_c))); // R6

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_wy) && $stable(out_wx)
                                    && $stable(out_ic) && $stable(out_oc) && $stable(out_zero)); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid); // R8

    AST_VALID_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> out_valid || done); // R8
endmodule

bind wss_seq wss_seq_chk #(.K_W(K_W), .D_W(D_W), .CW(CW), .OCW(OCW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_kh(cfg_kh), .cfg_kw(cfg_kw), .cfg_idepth(cfg_idepth), .cfg_odepth(cfg_odepth),
    .cfg_mode(cfg_mode), .out_valid(out_valid), .out_ready(out_ready),
    .out_wy(out_wy), .out_wx(out_wx), .out_ic(out_ic), .out_oc(out_oc),
    .out_zero(out_zero), .done(done)
);

// File: tb/wss_seq_bench.sv
// Scoreboard bench: a generator fills the expected queue from the walk rules,
// a monitor pops and compares on every handshake.
module wss_seq_bench;
    localparam int K_W = 4, D_W = 10, OUB = 8, IUB = 8, SUB_H = 8, SUB_W = 8;
    localparam int EL_W = $clog2(SUB_H * SUB_W + 4);
    localparam int CW   = ((K_W > EL_W) ? K_W : EL_W) + 1;
    localparam int OCW  = D_W + 1;

    logic clk = 1'b0, rst_n, start, cfg_wide, out_valid, out_ready, out_zero, done;
    logic [K_W-1:0] cfg_kh, cfg_kw;
    logic [D_W-1:0] cfg_idepth, cfg_odepth, cfg_oblk;
    logic [1:0]     cfg_mode;
    logic [CW-1:0]  out_wy, out_wx;
    logic [OCW-1:0] out_ic, out_oc;

    wss_seq #(.K_W(K_W), .D_W(D_W), .OUB(OUB), .IUB(IUB), .SUB_H(SUB_H), .SUB_W(SUB_W)) u_wss_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_kh(cfg_kh), .cfg_kw(cfg_kw), .cfg_idepth(cfg_idepth), .cfg_odepth(cfg_odepth),
        .cfg_oblk(cfg_oblk), .cfg_mode(cfg_mode), .cfg_wide(cfg_wide),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_wy(out_wy), .out_wx(out_wx), .out_ic(out_ic), .out_oc(out_oc),
        .out_zero(out_zero), .done(done)
    );

    always #5 clk = ~clk;

    typedef struct { int wy; int wx; int ic; int oc; int z; } item_t;
    item_t exp_q[$];
    int    n_chk = 0, n_fail = 0, cyc = 0, last_pop = -10;
    bit    all_ready = 1'b1;
    string cur_tag = "R1";
    logic [15:0] lfsr = 16'hACE1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    function automatic int rup(input int v, input int m);
        return ((v + m - 1) / m) * m;
    endfunction

    // Expected sequence built from the walk rules (driver side of the scoreboard).
    task automatic gen(input int mode, input int wide, input int kh, input int kw,
                       input int id, input int od, input int ob);
        int ibd, cob, cib, sh, sw, ne, outer, inner, ky, kx, ic, oc;
        item_t it;
        ibd = (mode == 1 || wide != 0) ? 16 : 32;
        for (int obz = 0; obz < od; obz += ob) begin
            cob = imin(ob, od - obz);
            for (int ibz = 0; ibz < ((mode == 2) ? 1 : id); ibz += ibd) begin
                cib = (mode == 2) ? IUB : ((mode == 1) ? imin(ibd, id - ibz) : ibd);
                for (int sy = 0; sy < kh; sy += SUB_H) begin
                    sh = imin(kh - sy, SUB_H);
                    for (int sx = 0; sx < kw; sx += SUB_W) begin
                        sw = imin(kw - sx, SUB_W);
                        ne = sh * sw;
                        if (mode == 1) ne = rup(ne, (wide != 0) ? 2 : 4);
                        else if (mode == 2) ne = rup(ne, 4);
                        outer = (mode == 1) ? cib : 1;
                        inner = (mode == 1) ? 1 : cib;
                        for (int iuo = 0; iuo < outer; iuo += IUB)
                          for (int ou = 0; ou < cob; ou += OUB)
                            for (int e = 0; e < ne; e++) begin
                                kx = e % sw; ky = e / sw;
                                for (int iui = 0; iui < inner; iui += IUB)
                                  for (int oz = 0; oz < OUB; oz++)
                                    for (int iz = 0; iz < ((mode == 2) ? 1 : IUB); iz++) begin
                                        ic = ibz + iuo + iui + iz;
                                        oc = obz + ou + oz;
                                        it.wy = sy + ky; it.wx = sx + kx;
                                        it.ic = ic; it.oc = oc;
                                        it.z  = (ic >= id || oc >= od || ky >= sh) ? 1 : 0;
                                        exp_q.push_back(it);
                                    end
                            end
                    end
                end
            end
        end
    endtask

    // Monitor: chooses ready, checks stall hold, pops and compares accepted items.
    initial begin : monitor
        bit prev_stall = 1'b0;
        item_t pv, e;
        out_ready = 1'b0;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = all_ready || (lfsr[1:0] != 2'b00);
            #1;
            if (prev_stall) begin
                chk("R7", "valid held in stall", int'(out_valid), 1);
                chk("R7", "wy held", int'(out_wy), pv.wy);
                chk("R7", "oc held", int'(out_oc), pv.oc);
                chk("R7", "ic held", int'(out_ic), pv.ic);
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk("R8", "unexpected extra coordinate", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(cur_tag, "wy", int'(out_wy), e.wy);
                    chk(cur_tag, "wx", int'(out_wx), e.wx);
                    chk(cur_tag, "ic", int'(out_ic), e.ic);
                    chk(cur_tag, "oc", int'(out_oc), e.oc);
                    chk("R6", "zero flag", int'(out_zero), e.z);
                    last_pop = cyc;
                end
            end
            prev_stall = out_valid && !out_ready;
            pv.wy = int'(out_wy); pv.oc = int'(out_oc); pv.ic = int'(out_ic);
        end
    end

    task automatic run_case(input string t, input int mode, input int wide, input int kh,
                            input int kw, input int id, input int od, input int ob,
                            input bit rdy_all, input bit poke);
        int k = 0;
        cur_tag = t;
        all_ready = rdy_all;
        gen(mode, wide, kh, kw, id, od, ob);
        @(negedge clk); #2;
        cfg_mode = 2'(mode); cfg_wide = 1'(wide); cfg_kh = K_W'(kh); cfg_kw = K_W'(kw);
        cfg_idepth = D_W'(id); cfg_odepth = D_W'(od); cfg_oblk = D_W'(ob);
        start = 1'b1;
        @(negedge clk); #2;
        start = 1'b0;
        forever begin
            @(negedge clk); #2;
            k++;
            if (poke && k == 40) begin
                // R9: restart attempt with a different configuration mid-walk
                start = 1'b1; cfg_mode = 2'd0; cfg_kh = 4'd2; cfg_kw = 4'd5;
                cfg_idepth = D_W'(3); cfg_odepth = D_W'(3); cfg_oblk = D_W'(2); cfg_wide = 1'b1;
            end
            if (poke && k == 41) start = 1'b0;
            if (done) break;
        end
        chk("R8", "queue drained at done", exp_q.size(), 0);
        chk("R8", "done one cycle after final accept", cyc, last_pop + 1);
        chk("R8", "valid low with done", int'(out_valid), 0);
        if (poke) chk("R9", "walk unaffected by busy start", exp_q.size(), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; cfg_mode = 2'd0; cfg_wide = 1'b0;
        cfg_kh = '0; cfg_kw = '0; cfg_idepth = '0; cfg_odepth = '0; cfg_oblk = '0;
        repeat (3) @(negedge clk);
        #2;
        chk("R1", "valid in reset", int'(out_valid), 0);
        chk("R1", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk); #2;
        chk("R1", "valid after reset", int'(out_valid), 0);
        run_case("R2",  0, 0, 3, 3, 20, 12, 8, 1'b0, 1'b0);
        run_case("R3",  1, 0, 3, 3, 5, 8, 8, 1'b0, 1'b0);
        run_case("R3",  1, 1, 1, 3, 20, 8, 8, 1'b1, 1'b0);
        run_case("R4",  2, 0, 3, 3, 10, 10, 16, 1'b0, 1'b0);
        run_case("R5",  0, 1, 10, 9, 8, 8, 8, 1'b0, 1'b0);
        run_case("R10", 0, 1, 1, 1, 8, 20, 16, 1'b0, 1'b0);
        run_case("R9",  1, 0, 3, 3, 5, 8, 8, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule